// File: doc/BRIEF.md
# Byte-Oriented Two-Wire Bus Master with Status Codes

This block is a master for a two-wire serial bus (I2C style, open-drain SCL and SDA). Software steers it through a small register port: it loads a byte into the data register, then writes the control register to ask for one bus step. That step is a start, a repeated start, one byte out, one byte in, or a stop. The block performs the step on the wires. When the step ends, it raises a completion flag and publishes one 8-bit status code that describes the new bus state. The next step begins only when software writes control again with the flag bit written as zero.

Each bit takes ten slots, and each slot lasts `(M+1)*2^N` system clocks. M and N come from the baud register, so one SCL period is `10*(M+1)*2^N` clocks. While the completion flag is pending inside a transfer, the master holds SCL low. A write of any value to the soft-reset offset returns the sequencer to idle.

The sequencer has five states: `ST_IDLE`, `ST_START`, `ST_BYTE`, `ST_STOP` and `ST_HOLD`. Its transitions are:
- **launch-start**: IDLE or HOLD goes to START.
- **launch-byte**: HOLD goes to BYTE.
- **launch-stop**: HOLD goes to STOP.
- **start-done**: START goes to HOLD.
- **byte-done**: BYTE goes to HOLD after the ninth bit.
- **arb-lost**: BYTE goes to HOLD at the sample slot.
- **stop-done**: STOP goes to IDLE.
- **stop-restart**: STOP goes to START when a start was also requested.
- **soft-reset**: any state goes to IDLE.

Top module: `i2c_code_master`

## Requirements
- R1: After reset, the status register (offset 0x0C, read) reads 0xF8. The completion flag (control bit 3) reads 0, and neither SCL nor SDA is driven low.
- R2: A control write of 0x60 (enable 0x40 plus start 0x20) from an idle bus produces a start condition, in which SDA falls while SCL is high. It then sets the flag with status 0x08 and holds SCL low while the flag is pending.
- R3: A start requested while a transfer is open produces a repeated start, with status 0x10.
- R4: An address byte is sent MSB first, and its bit 0 selects the direction. The status is 0x18 or 0x20 for a write address with ACK or NACK, and 0x40 or 0x48 for a read address with ACK or NACK. SDA changes only while SCL is low.
- R5: A data byte sent in write direction gives status 0x28 on ACK and 0x30 on NACK.
- R6: In read direction, the received byte is placed in the data register (offset 0x04). With control bit 2 (ACK) set, the master acknowledges and the status is 0x50. With bit 2 clear, it returns NACK and the status is 0x58.
- R7: A stop request (0x10) produces SDA rising while SCL is high. The status becomes 0xF8, and the flag stays clear.
- R8: Start and stop requested in one control write inside an open transfer produce a stop and then a fresh start, reporting status 0x08.
- R9: A control write while a step is in progress is ignored, including its field bits. A control write with bit 3 set, or with enable clear, launches nothing. The flag is never set while a step is in progress.
- R10: If the master leaves SDA high but samples it low while SCL is high during a transmitted bit, it releases both lines and reports status 0x38.
- R11: A write to offset 0x1C during any step returns the block to idle. The status becomes 0xF8, the flag clears and both lines are released.
- R12: The baud register (offset 0x0C, write) holds M in bits [6:3] and N in bits [2:0]. The SCL period is 10*(M+1)*2^N clocks.
- R13: A control read returns {int-enable, enable, 0, 0, flag, ACK, 0, 0}. `irq` is high exactly when both the flag and int-enable (bit 7) are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| sda_in | input | 1 | Sampled SDA wire level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
Two functions can land in the same control write: a stop and a start. Both bits are set at once while a transfer is open. The bench judges the result in two ways. A bus-side monitor must count exactly one new stop condition before the completion flag rises, and the status must read 0x08 rather than the repeated-start code 0x10. A second collision is a control write that arrives while a byte is on the wire. The bench issues it mid-byte and checks that the byte's own code survives, that no start follows, and that the ACK field bit of the ignored write is absent from the control readback.

// File: rtl/i2c_code_pkg.sv
package i2c_code_pkg;
    localparam int BAUD_M_W = 4;
    localparam int BAUD_N_W = 3;
    localparam int SLOT_W   = 4;
    localparam int BIT_W    = 4;

    localparam logic [SLOT_W-1:0] SLOT_EDGE   = 4'd0;
    localparam logic [SLOT_W-1:0] SLOT_SETUP  = 4'd2;
    localparam logic [SLOT_W-1:0] SLOT_MID    = 4'd5;
    localparam logic [SLOT_W-1:0] SLOT_SAMPLE = 4'd7;
    localparam logic [SLOT_W-1:0] SLOT_LAST   = 4'd9;
    localparam logic [BIT_W-1:0]  ACK_BIT     = 4'd8;

    localparam logic [4:0] OFS_DATA   = 5'h04;
    localparam logic [4:0] OFS_CTRL   = 5'h08;
    localparam logic [4:0] OFS_STBAUD = 5'h0C;
    localparam logic [4:0] OFS_SRST   = 5'h1C;

    localparam int CB_ACK   = 2;
    localparam int CB_FLAG  = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_EN    = 6;
    localparam int CB_IE    = 7;

    localparam logic [7:0] SC_START    = 8'h08;
    localparam logic [7:0] SC_RESTART  = 8'h10;
    localparam logic [7:0] SC_WA_ACK   = 8'h18;
    localparam logic [7:0] SC_WA_NACK  = 8'h20;
    localparam logic [7:0] SC_WD_ACK   = 8'h28;
    localparam logic [7:0] SC_WD_NACK  = 8'h30;
    localparam logic [7:0] SC_LOST     = 8'h38;
    localparam logic [7:0] SC_RA_ACK   = 8'h40;
    localparam logic [7:0] SC_RA_NACK  = 8'h48;
    localparam logic [7:0] SC_RD_ACK   = 8'h50;
    localparam logic [7:0] SC_RD_NACK  = 8'h58;
    localparam logic [7:0] SC_IDLE     = 8'hF8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BYTE,
        ST_STOP,
        ST_HOLD
    } seq_state_t;
endpackage

// File: rtl/i2c_code_tick.sv
module i2c_code_tick #(
    parameter int M_W = 4,
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [M_W-1:0] div_m,
    input  logic [N_W-1:0] div_n,
    output logic           tick
);
    localparam int CW = M_W + (1 << N_W);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = (CW'(div_m) + CW'(1)) << div_n;
    assign tick  = (cnt_q >= limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    assert_tick_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && limit > CW'(1)) |=> (!tick || limit != $past(limit)));
endmodule

// File: rtl/i2c_code_seq.sv
module i2c_code_seq
    import i2c_code_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       tick,
    input  logic       launch,
    input  logic       want_start,
    input  logic       want_stop,
    input  logic       ack_en,
    input  logic       data_we,
    input  logic [7:0] data_wdata,
    input  logic       sda_in,
    output logic       scl_low,
    output logic       sda_low,
    output logic       done,
    output logic       busy,
    output logic [7:0] status,
    output logic [7:0] byte_q
);
    seq_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic [7:0]        sh_q;
    logic              in_txn, addr_next, rd_mode, pend_q, got_ack;
    logic              xmit, lose;

    assign busy = (state_q == ST_START) || (state_q == ST_BYTE) || (state_q == ST_STOP);
    assign xmit = addr_next || !rd_mode;
    assign lose = xmit && sh_q[7] && !sda_in;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HOLD: begin
                if (launch) begin
                    if (want_stop && in_txn)  state_d = ST_STOP;
                    else if (want_start)      state_d = ST_START;
                    else if (in_txn)          state_d = ST_BYTE;
                end
            end
            ST_START: if (tick && slot_q == SLOT_LAST) state_d = ST_HOLD;
            ST_BYTE: begin
                if (tick && slot_q == SLOT_SAMPLE && bit_q < ACK_BIT && lose)
                    state_d = ST_HOLD;
                else if (tick && slot_q == SLOT_LAST && bit_q == ACK_BIT)
                    state_d = ST_HOLD;
            end
            ST_STOP: if (tick && slot_q == SLOT_LAST) state_d = pend_q ? ST_START : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (soft_rst) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0; bit_q <= '0; sh_q <= '0; byte_q <= '0;
            in_txn <= 1'b0; addr_next <= 1'b0; rd_mode <= 1'b0;
            pend_q <= 1'b0; got_ack <= 1'b0;
            scl_low <= 1'b0; sda_low <= 1'b0;
            status <= SC_IDLE; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (soft_rst) begin
                slot_q <= '0; in_txn <= 1'b0; addr_next <= 1'b0; pend_q <= 1'b0;
                scl_low <= 1'b0; sda_low <= 1'b0; status <= SC_IDLE;
            end else begin
                if (data_we) byte_q <= data_wdata;
                if (launch && !busy) begin
                    slot_q <= '0;
                    bit_q  <= '0;
                    sh_q   <= byte_q;
                    pend_q <= want_start && want_stop && in_txn;
                    if (addr_next) rd_mode <= byte_q[0];
                end else if (tick && busy) begin
                    slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
                    unique case (state_q)
                        ST_START: begin
                            if (slot_q == SLOT_EDGE)  sda_low <= 1'b0;
                            if (slot_q == SLOT_SETUP) scl_low <= 1'b0;
                            if (slot_q == SLOT_MID)   sda_low <= 1'b1;
                            if (slot_q == SLOT_LAST) begin
                                scl_low   <= 1'b1;
                                status    <= in_txn ? SC_RESTART : SC_START;
                                in_txn    <= 1'b1;
                                addr_next <= 1'b1;
                                done      <= 1'b1;
                            end
                        end
                        ST_BYTE: begin
                            if (slot_q == SLOT_SETUP)
                                sda_low <= (bit_q < ACK_BIT) ? (xmit && !sh_q[7]) : (!xmit && ack_en);
                            if (slot_q == SLOT_MID) scl_low <= 1'b0;
                            if (slot_q == SLOT_SAMPLE) begin
                                if (bit_q == ACK_BIT) begin
                                    got_ack <= !sda_in;
                                end else if (lose) begin
                                    sda_low   <= 1'b0;
                                    in_txn    <= 1'b0;
                                    addr_next <= 1'b0;
                                    status    <= SC_LOST;
                                    done      <= 1'b1;
                                end else begin
                                    sh_q <= {sh_q[6:0], sda_in};
                                end
                            end
                            if (slot_q == SLOT_LAST) begin
                                scl_low <= 1'b1;
                                if (bit_q == ACK_BIT) begin
                                    done      <= 1'b1;
                                    addr_next <= 1'b0;
                                    if (addr_next)
                                        status <= rd_mode ? (got_ack ? SC_RA_ACK : SC_RA_NACK)
                                                          : (got_ack ? SC_WA_ACK : SC_WA_NACK);
                                    else if (rd_mode) begin
                                        status <= ack_en ? SC_RD_ACK : SC_RD_NACK;
                                        byte_q <= sh_q;
                                    end else
                                        status <= got_ack ? SC_WD_ACK : SC_WD_NACK;
                                end else begin
                                    bit_q <= bit_q + 1'b1;
                                end
                            end
                        end
                        ST_STOP: begin
                            if (slot_q == SLOT_EDGE)  sda_low <= 1'b1;
                            if (slot_q == SLOT_SETUP) scl_low <= 1'b0;
                            if (slot_q == SLOT_MID)   sda_low <= 1'b0;
                            if (slot_q == SLOT_LAST) begin
                                in_txn    <= 1'b0;
                                addr_next <= 1'b0;
                                pend_q    <= 1'b0;
                                status    <= SC_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assert_soft_reset_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status == SC_IDLE && !scl_low && !sda_low && state_q == ST_IDLE));

    assert_hold_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && in_txn) |-> scl_low);

    assert_sda_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYTE && $past(state_q) == ST_BYTE && !scl_low && !$past(scl_low))
        |-> $stable(sda_low));

    assert_stop_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && $past(state_q) == ST_STOP && !sda_low && $past(sda_low))
        |-> !scl_low);

    assert_lost_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == SC_LOST) |-> (!scl_low && !sda_low));
endmodule

// File: rtl/i2c_code_master.sv
module i2c_code_master
    import i2c_code_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low
);
    logic                         ctl_ack, ctl_en, ctl_ie, flag_q;
    logic [BAUD_M_W+BAUD_N_W-1:0] baud_q;
    logic                         ctrl_we, data_we, baud_we, srst_we, launch;
    logic                         busy, seq_done, tick;
    logic [7:0]                   status, byte_q;

    assign ctrl_we = reg_we && reg_addr == OFS_CTRL;
    assign data_we = reg_we && reg_addr == OFS_DATA && !busy;
    assign baud_we = reg_we && reg_addr == OFS_STBAUD;
    assign srst_we = reg_we && reg_addr == OFS_SRST;
    assign launch  = ctrl_we && !busy && !reg_wdata[CB_FLAG] && reg_wdata[CB_EN];
    assign irq     = flag_q && ctl_ie;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_ack <= 1'b0; ctl_en <= 1'b0; ctl_ie <= 1'b0;
            flag_q  <= 1'b0; baud_q <= '0;
        end else begin
            if (srst_we)                                      flag_q <= 1'b0;
            else if (seq_done)                                flag_q <= 1'b1;
            else if (ctrl_we && !busy && !reg_wdata[CB_FLAG]) flag_q <= 1'b0;
            if (ctrl_we && !busy) begin
                ctl_ack <= reg_wdata[CB_ACK];
                ctl_en  <= reg_wdata[CB_EN];
                ctl_ie  <= reg_wdata[CB_IE];
            end
            if (baud_we) baud_q <= reg_wdata[BAUD_M_W+BAUD_N_W-1:0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_DATA:   reg_rdata = byte_q;
            OFS_CTRL:   reg_rdata = {ctl_ie, ctl_en, 2'b00, flag_q, ctl_ack, 2'b00};
            OFS_STBAUD: reg_rdata = status;
            default:    reg_rdata = 8'h00;
        endcase
    end

    i2c_code_tick #(.M_W(BAUD_M_W), .N_W(BAUD_N_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .div_m (baud_q[BAUD_M_W+BAUD_N_W-1:BAUD_N_W]),
        .div_n (baud_q[BAUD_N_W-1:0]),
        .tick  (tick)
    );

    i2c_code_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (srst_we),
        .tick       (tick),
        .launch     (launch),
        .want_start (reg_wdata[CB_START]),
        .want_stop  (reg_wdata[CB_STOP]),
        .ack_en     (ctl_ack),
        .data_we    (data_we),
        .data_wdata (reg_wdata),
        .sda_in     (sda_in),
        .scl_low    (scl_drive_low),
        .sda_low    (sda_drive_low),
        .done       (seq_done),
        .busy       (busy),
        .status     (status),
        .byte_q     (byte_q)
    );

    assert_flag_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> !busy);
endmodule

// File: tb/sim_i2c_code_master.sv
module sim_i2c_code_master;
    localparam int CLK_P = 10;
    localparam logic [6:0] SLV = 7'h50;
    localparam logic [4:0] A_DATA = 5'h04, A_CTRL = 5'h08, A_STB = 5'h0C, A_SRST = 5'h1C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq, scl_drive_low, sda_drive_low;
    logic s_oe = 1'b0, bully = 1'b0;
    wire scl_line = !scl_drive_low;
    wire sda_line = !(sda_drive_low || s_oe || bully);

    int checks = 0, fails = 0;
    int start_cnt = 0, stop_cnt = 0;
    int cyc = 0, last_rise = 0, per = 0;

    always #(CLK_P/2) clk = ~clk;

    i2c_code_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sda_in(sda_line), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    // bus-side target model, evaluated on the falling clock edge
    int s_bit = -1;
    logic s_addr = 0, s_sel = 0, s_tx = 0, s_macked = 0;
    logic [7:0] s_sh = 0, s_txb = 0, s_ptr = 8'h3C, s_last = 0;
    logic p_scl = 1, p_sda = 1, m_pscl = 1;

    always @(negedge clk) begin
        cyc++;
        if (scl_line && !m_pscl) begin per = cyc - last_rise; last_rise = cyc; end
        m_pscl = scl_line;
        if (rst_n) begin
            if (scl_line && p_scl && p_sda && !sda_line) begin
                s_bit = -1; s_addr = 1; s_sel = 0; s_tx = 0; s_oe = 0; start_cnt++;
            end else if (scl_line && p_scl && !p_sda && sda_line) begin
                s_bit = -1; s_addr = 0; s_sel = 0; s_tx = 0; s_oe = 0; stop_cnt++;
            end else if (scl_line && !p_scl) begin
                if (s_bit >= 0 && s_bit < 8 && !s_tx) s_sh = {s_sh[6:0], sda_line};
                if (s_bit == 8 && s_tx) s_macked = !sda_line;
            end else if (!scl_line && p_scl) begin
                if (s_bit == 8) begin
                    if (s_addr) begin
                        s_addr = 0; s_sel = (s_sh[7:1] == SLV); s_tx = s_sel && s_sh[0];
                        if (s_tx) begin s_txb = s_ptr; s_ptr++; end
                    end else if (s_tx) begin
                        if (s_macked) begin s_txb = s_ptr; s_ptr++; end
                        else begin s_tx = 0; s_sel = 0; end
                    end else if (s_sel) s_last = s_sh;
                    s_bit = 0;
                end else s_bit = s_bit + 1;
                if (s_bit < 8) s_oe = s_tx ? !s_txb[7 - s_bit] : 1'b0;
                else s_oe = s_tx ? 1'b0 : (s_addr ? (s_sh[7:1] == SLV) : (s_sel && s_sh != 8'hFF));
            end
        end
        p_scl = scl_line; p_sda = sda_line;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #2; d = reg_rdata;
    endtask

    task automatic wait_flag();
        logic [7:0] c;
        int n = 0;
        rd(A_CTRL, c);
        while (!c[3] && n < 20000) begin rd(A_CTRL, c); n++; end
        if (!c[3]) chk("flag timeout", 0, 1);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int n = 0;
        rd(A_STB, s);
        while (s != 8'hF8 && n < 20000) begin rd(A_STB, s); n++; end
    endtask

    task automatic step(input logic [7:0] ctl, input logic [7:0] exp, input string req);
        logic [7:0] s;
        wr(A_CTRL, ctl); wait_flag(); rd(A_STB, s); chk(req, s, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int sc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_STB, v);  chk("R1 status", v, 8'hF8);
        rd(A_CTRL, v); chk("R1 flag", v[3], 0);
        chk("R1 lines", {scl_drive_low, sda_drive_low}, 0);
        wr(A_STB, 8'h08);               // M=1 N=0
        wr(A_CTRL, 8'h40);
        // R2 start
        step(8'h60, 8'h08, "R2 start code");
        chk("R2 scl held", scl_drive_low, 1);
        chk("R2 start seen", start_cnt, 1);
        // R4 write address, R5 write data
        wr(A_DATA, 8'hA0); step(8'h40, 8'h18, "R4 wr addr ack");
        wr(A_DATA, 8'h5A); step(8'h40, 8'h28, "R5 wr data ack");
        chk("R5 target got byte", s_last, 8'h5A);
        // R9 write while busy ignored
        wr(A_DATA, 8'h77); wr(A_CTRL, 8'h40); wr(A_CTRL, 8'h64);
        wait_flag(); rd(A_STB, v); chk("R9 busy write status", v, 8'h28);
        repeat (300) @(negedge clk);
        rd(A_STB, v);  chk("R9 no start after", v, 8'h28);
        rd(A_CTRL, v); chk("R9 fields kept", v, 8'h48);
        chk("R9 scl still held", scl_drive_low, 1);
        chk("R5 second byte", s_last, 8'h77);
        wr(A_CTRL, 8'h68); repeat (300) @(negedge clk);
        rd(A_STB, v); chk("R9 flag-set write", v, 8'h28);
        // R3 repeated start, R4 read address, R6 reads
        step(8'h60, 8'h10, "R3 repeated start");
        wr(A_DATA, 8'hA1); step(8'h40, 8'h40, "R4 rd addr ack");
        step(8'h44, 8'h50, "R6 read ack");
        rd(A_DATA, v); chk("R6 byte0", v, 8'h3C);
        step(8'h40, 8'h58, "R6 read nack");
        rd(A_DATA, v); chk("R6 byte1", v, 8'h3D);
        // R7 stop
        sc = stop_cnt;
        wr(A_CTRL, 8'h50); wait_idle();
        rd(A_CTRL, v); chk("R7 flag clear", v[3], 0);
        chk("R7 lines released", {scl_drive_low, sda_drive_low}, 0);
        chk("R7 stop seen", stop_cnt, sc + 1);
        // R4 nack on write address, R8 stop+start together
        step(8'h60, 8'h08, "R2 start again");
        wr(A_DATA, 8'h66); step(8'h40, 8'h20, "R4 wr addr nack");
        sc = stop_cnt;
        step(8'h70, 8'h08, "R8 stop then start");
        chk("R8 stop on bus", stop_cnt, sc + 1);
        wr(A_DATA, 8'h67); step(8'h40, 8'h48, "R4 rd addr nack");
        // R13 control readback and irq
        wr(A_CTRL, 8'hC8);
        rd(A_CTRL, v); chk("R13 ctrl read", v, 8'hC8);
        chk("R13 irq set", irq, 1);
        step(8'hE0, 8'h10, "R3 restart with ie");
        wr(A_DATA, 8'hA0); step(8'hC0, 8'h18, "R4 wr addr ack 2");
        wr(A_DATA, 8'hFF); step(8'hC0, 8'h30, "R5 wr data nack");
        wr(A_CTRL, 8'hD0); wait_idle();
        chk("R13 irq clear", irq, 0);
        wr(A_CTRL, 8'h40);
        // R11 soft reset mid-byte
        step(8'h60, 8'h08, "R2 start before reset");
        wr(A_DATA, 8'hA0); wr(A_CTRL, 8'h40);
        repeat (30) @(negedge clk);
        wr(A_SRST, 8'h00);
        rd(A_STB, v);  chk("R11 status", v, 8'hF8);
        rd(A_CTRL, v); chk("R11 flag", v[3], 0);
        chk("R11 lines", {scl_drive_low, sda_drive_low}, 0);
        repeat (20) @(negedge clk);
        // R10 arbitration loss on first address bit
        step(8'h60, 8'h08, "R2 start before arb");
        wr(A_DATA, 8'hA0); bully = 1'b1;
        step(8'h40, 8'h38, "R10 arb lost code");
        chk("R10 released", {scl_drive_low, sda_drive_low}, 0);
        bully = 1'b0;
        repeat (20) @(negedge clk);
        // R12 bit period sweep
        for (int m = 0; m < 3; m++) begin
            for (int n = 0; n < 3; n++) begin
                wr(A_STB, 8'((m << 3) | n));
                step(8'h60, 8'h08, "R12 start");
                wr(A_DATA, 8'hA0); step(8'h40, 8'h18, "R12 addr");
                chk("R12 scl period", per, 10 * (m + 1) * (1 << n));
                wr(A_CTRL, 8'h50); wait_idle();
            end
        end
        finish_run();
    end
endmodule